// File: doc/BRIEF.md
# Multi-Channel Trace Packet Serializer

This block is a debug trace emitter for a large chip. Three command channels each own a small register bank. Software fills a channel's four 16-bit parameter slots, then writes the channel's command word with a header byte and a parameter count. That write queues one packet. When the serial line is free, a fixed-priority arbiter picks one queued channel. The packet is then shifted out MSB first on a single data line, with a companion bit clock. The packet carries a start marker, the channel number, the header, an optional 16-bit timestamp and the requested parameters.

The bit clock comes from the system clock through a divider that software can select at runtime. Each half of a bit-clock period lasts one to four system clocks. The data line changes only while the bit clock is low, so an external receiver samples on the rising edge. A free-running 16-bit timestamp counter advances while timestamps are enabled. Software can zero it with a write-one pulse bit in the configuration word. The command fields of a channel read back as zero once the channel can take a new command, which gives software a readiness flag with no separate status bit.

Top module: `trc_serializer`

## Requirements
- R1: After reset the configuration word, all command words and all parameter words read 0, and both the bit clock and the data line are low.
- R2: The register map uses byte addresses with bits [1:0] ignored. The configuration word is at 0x00. Command words for channels 1..3 are at 0x04/0x08/0x0C. Parameters 0 and 1 are at 0x14/0x18/0x1C, with parameter 0 in bits [15:0] and parameter 1 in bits [31:16]. Parameters 2 and 3 are at 0x24/0x28/0x2C, with parameter 2 in [15:0] and parameter 3 in [31:16]. Parameter words read back what was written. The configuration word holds the channel enables in bits [2:0] (bit i for channel i+1), the timestamp enable in bit 3, the timestamp clear in bit 4 and the divider code in bits [7:6].
- R3: A command write to an enabled, idle channel queues a packet. The header is taken from bits [15:8] and the count from bits [2:0]. Both fields read back as written until the packet's last bit has been sent, and read 0 from then on.
- R4: A frame is, in order: a start bit of 1, the 2-bit channel number (1..3), the 8-bit header, the 16-bit timestamp if enabled, then the parameters in index order. Every field is sent MSB first. Between frames both the data line and the bit clock are low.
- R5: A parameter count of 0 sends the header only (11 bits). A count above 4 sends all four parameters (75 bits).
- R6: With divider code n (0..3), the bit clock stays low for n+1 system clocks and then high for n+1 system clocks for each bit. The data line changes only while the bit clock is low.
- R7: The timestamp field is present only when the timestamp enable was set when the packet started. The counter advances by one each system clock while enabled and holds otherwise. The value sent is the counter value in the cycle before the start bit appears.
- R8: Writing the configuration word with bit 4 set zeroes the timestamp counter, and the clear takes priority over counting. Bit 4 always reads 0.
- R9: A command write to a disabled channel is ignored: its fields stay 0 and no frame is sent.
- R10: When several channels are queued, channel 1 goes first, then channel 2, then channel 3. A frame in progress is never cut short by a higher-priority request.
- R11: A command write to a channel that is already queued or sending is ignored, and its fields keep the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| trc_clk | output | 1 | Divided bit clock, low when idle |
| trc_dat | output | 1 | Serial trace data, low when idle |

## Verification
The hardest case to reach from the ports is contention: two or more channels queued at once while a lower-priority frame is already on the wire. The priority rule and the no-preemption rule only show in that situation. The bench first queues channel 3 on an idle line, so it starts at once. While that frame is still shifting, it queues channel 2 and then channel 1, and it also sends a second command to the already-queued channel 2. The decoded bit stream must then show the channels in the order 3, 1, 2, with the original channel 2 header. A dedicated sequence makes the timestamp predictable. The bench enables and clears the counter in the same write, then compares the transmitted field with a counter model kept in the bench.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int NCH     = 3;
    localparam int HDR_W   = 8;
    localparam int PAR_W   = 16;
    localparam int NPAR    = 4;
    localparam int TS_W    = 16;
    localparam int CNT_W   = 3;
    localparam int CHN_W   = 2;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int PRE_W   = 2;

    // configuration word layout
    localparam int TSEN_BIT  = 3;
    localparam int TSCLR_BIT = 4;
    localparam int PRE_LSB   = 6;
    // command word layout
    localparam int HDR_LSB   = 8;

    // address groups (reg_addr[5:4])
    localparam logic [1:0] GRP_CMD  = 2'd0;
    localparam logic [1:0] GRP_P01  = 2'd1;
    localparam logic [1:0] GRP_P23  = 2'd2;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             tsen;
        logic [NCH-1:0]   en;
    } cfg_t;
endpackage

// File: rtl/trc_regs.sv
module trc_regs
    import trc_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic                                 wr,
    input  logic [DATA_W-1:0]                    wdata,
    output logic [DATA_W-1:0]                    rdata,
    input  logic                                 done,
    input  logic [CHN_W-1:0]                     done_ch,
    output cfg_t                                 cfg,
    output logic                                 ts_clr,
    output logic [NCH-1:0]                       pend,
    output logic [NCH-1:0][HDR_W-1:0]            hdr,
    output logic [NCH-1:0][CNT_W-1:0]            cnt,
    output logic [NCH-1:0][NPAR-1:0][PAR_W-1:0]  par
);
    typedef struct packed {
        cfg_t                                cfg;
        logic [NCH-1:0]                      pend;
        logic [NCH-1:0][HDR_W-1:0]           hdr;
        logic [NCH-1:0][CNT_W-1:0]           cnt;
        logic [NCH-1:0][NPAR-1:0][PAR_W-1:0] par;
    } st_t;

    st_t        st_d, st_q;
    logic [1:0] grp;
    logic [1:0] idx;
    logic       bits_unused;

    assign grp         = addr[5:4];
    assign idx         = addr[3:2];
    assign bits_unused = ^{addr[1:0], wdata};

    // read path
    always_comb begin
        rdata = '0;
        if (grp == GRP_CMD && idx == 2'd0) begin
            rdata[NCH-1:0]            = st_q.cfg.en;
            rdata[TSEN_BIT]           = st_q.cfg.tsen;
            rdata[PRE_LSB +: PRE_W]   = st_q.cfg.pre;
        end
        for (int i = 0; i < NCH; i++) begin
            if (idx == 2'(i + 1)) begin
                case (grp)
                    GRP_CMD: begin
                        rdata[HDR_LSB +: HDR_W] = st_q.hdr[i];
                        rdata[CNT_W-1:0]        = st_q.cnt[i];
                    end
                    GRP_P01: rdata = {st_q.par[i][1], st_q.par[i][0]};
                    GRP_P23: rdata = {st_q.par[i][3], st_q.par[i][2]};
                    default: rdata = '0;
                endcase
            end
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        ts_clr = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (done && done_ch == CHN_W'(i + 1)) begin
                st_d.pend[i] = 1'b0;
                st_d.hdr[i]  = '0;
                st_d.cnt[i]  = '0;
            end
        end
        if (wr) begin
            if (grp == GRP_CMD && idx == 2'd0) begin
                st_d.cfg.en   = wdata[NCH-1:0];
                st_d.cfg.tsen = wdata[TSEN_BIT];
                st_d.cfg.pre  = wdata[PRE_LSB +: PRE_W];
                ts_clr        = wdata[TSCLR_BIT];
            end
            for (int i = 0; i < NCH; i++) begin
                if (idx == 2'(i + 1)) begin
                    case (grp)
                        GRP_CMD: begin
                            if (st_q.cfg.en[i] && !st_q.pend[i]) begin
                                st_d.pend[i] = 1'b1;
                                st_d.hdr[i]  = wdata[HDR_LSB +: HDR_W];
                                st_d.cnt[i]  = wdata[CNT_W-1:0];
                            end
                        end
                        GRP_P01: begin
                            st_d.par[i][0] = wdata[PAR_W-1:0];
                            st_d.par[i][1] = wdata[2*PAR_W-1:PAR_W];
                        end
                        GRP_P23: begin
                            st_d.par[i][2] = wdata[PAR_W-1:0];
                            st_d.par[i][3] = wdata[2*PAR_W-1:PAR_W];
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg  = st_q.cfg;
    assign pend = st_q.pend;
    assign hdr  = st_q.hdr;
    assign cnt  = st_q.cnt;
    assign par  = st_q.par;
endmodule

// File: rtl/trc_arb.sv
module trc_arb
    import trc_pkg::*;
(
    input  logic             busy,
    input  logic [NCH-1:0]   pend,
    input  logic [NCH-1:0]   en,
    output logic             load,
    output logic [NCH-1:0]   grant,
    output logic [CHN_W-1:0] gnum
);
    logic [NCH-1:0] req;

    always_comb begin
        req   = pend & en;
        grant = '0;
        gnum  = '0;
        // lowest index wins
        for (int i = 0; i < NCH; i++) begin
            if (req[i] && grant == '0) begin
                grant[i] = 1'b1;
                gnum     = CHN_W'(i + 1);
            end
        end
        load = !busy && (|req);
    end
endmodule

// File: rtl/trc_tstamp.sv
module trc_tstamp
    import trc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tsen,
    input  logic            clr,
    output logic [TS_W-1:0] ts
);
    typedef struct packed {
        logic [TS_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)       st_d.cnt = '0;
        else if (tsen) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ts = st_q.cnt;
endmodule

// File: rtl/trc_shift.sv
module trc_shift
    import trc_pkg::*;
#(
    parameter int FRAME_W = 1 + CHN_W + HDR_W + TS_W + NPAR * PAR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [CHN_W-1:0]            ld_ch,
    input  logic [HDR_W-1:0]            ld_hdr,
    input  logic [CNT_W-1:0]            ld_cnt,
    input  logic [NPAR-1:0][PAR_W-1:0]  ld_par,
    input  logic [TS_W-1:0]             ld_ts,
    input  logic                        ld_tsen,
    input  logic [PRE_W-1:0]            ld_pre,
    output logic                        busy,
    output logic                        done,
    output logic [CHN_W-1:0]            done_ch,
    output logic                        bclk,
    output logic                        bdat
);
    localparam int LEN_W  = $clog2(FRAME_W + 1);
    localparam int HEAD_W = 1 + CHN_W + HDR_W;

    typedef struct packed {
        logic               busy;
        logic               phase;
        logic [PRE_W-1:0]   pre;
        logic [PRE_W-1:0]   div;
        logic [LEN_W-1:0]   left;
        logic [FRAME_W-1:0] sh;
        logic [CHN_W-1:0]   ch;
    } st_t;

    st_t                st_d, st_q;
    logic [FRAME_W-1:0] acc;
    int                 len;
    int                 ncl;

    // frame assembly, left aligned
    always_comb begin
        acc = FRAME_W'({1'b1, ld_ch, ld_hdr});
        len = HEAD_W;
        if (ld_tsen) begin
            acc = (acc << TS_W) | FRAME_W'(ld_ts);
            len = len + TS_W;
        end
        ncl = (int'(ld_cnt) > NPAR) ? NPAR : int'(ld_cnt);
        for (int i = 0; i < NPAR; i++) begin
            if (i < ncl) begin
                acc = (acc << PAR_W) | FRAME_W'(ld_par[i]);
                len = len + PAR_W;
            end
        end
        acc = acc << (FRAME_W - len);
    end

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (st_q.busy) begin
            if (st_q.div == st_q.pre) begin
                st_d.div = '0;
                if (!st_q.phase) begin
                    st_d.phase = 1'b1;
                end else if (st_q.left == LEN_W'(1)) begin
                    st_d.busy  = 1'b0;
                    st_d.phase = 1'b0;
                    st_d.sh    = '0;
                    done       = 1'b1;
                end else begin
                    st_d.phase = 1'b0;
                    st_d.sh    = st_q.sh << 1;
                    st_d.left  = st_q.left - 1'b1;
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end else if (load) begin
            st_d.busy  = 1'b1;
            st_d.phase = 1'b0;
            st_d.div   = '0;
            st_d.pre   = ld_pre;
            st_d.left  = LEN_W'(len);
            st_d.sh    = acc;
            st_d.ch    = ld_ch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done_ch = st_q.ch;
    assign bclk    = st_q.busy & st_q.phase;
    assign bdat    = st_q.sh[FRAME_W-1];
endmodule

// File: rtl/trc_serializer.sv
module trc_serializer
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              trc_clk,
    output logic              trc_dat
);
    cfg_t                                cfg;
    logic                                ts_clr;
    logic [NCH-1:0]                      pend;
    logic [NCH-1:0][HDR_W-1:0]           hdr_a;
    logic [NCH-1:0][CNT_W-1:0]           cnt_a;
    logic [NCH-1:0][NPAR-1:0][PAR_W-1:0] par_a;
    logic                                ser_busy;
    logic                                ser_done;
    logic [CHN_W-1:0]                    done_ch;
    logic                                arb_load;
    logic [NCH-1:0]                      arb_grant;
    logic [CHN_W-1:0]                    arb_num;
    logic [TS_W-1:0]                     ts_val;
    logic [HDR_W-1:0]                    sel_hdr;
    logic [CNT_W-1:0]                    sel_cnt;
    logic [NPAR-1:0][PAR_W-1:0]          sel_par;

    trc_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .done    (ser_done),
        .done_ch (done_ch),
        .cfg     (cfg),
        .ts_clr  (ts_clr),
        .pend    (pend),
        .hdr     (hdr_a),
        .cnt     (cnt_a),
        .par     (par_a)
    );

    trc_arb u_arb (
        .busy  (ser_busy),
        .pend  (pend),
        .en    (cfg.en),
        .load  (arb_load),
        .grant (arb_grant),
        .gnum  (arb_num)
    );

    trc_tstamp u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .tsen  (cfg.tsen),
        .clr   (ts_clr),
        .ts    (ts_val)
    );

    always_comb begin
        sel_hdr = '0;
        sel_cnt = '0;
        sel_par = '0;
        for (int i = 0; i < NCH; i++) begin
            if (arb_grant[i]) begin
                sel_hdr = hdr_a[i];
                sel_cnt = cnt_a[i];
                sel_par = par_a[i];
            end
        end
    end

    trc_shift u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (arb_load),
        .ld_ch   (arb_num),
        .ld_hdr  (sel_hdr),
        .ld_cnt  (sel_cnt),
        .ld_par  (sel_par),
        .ld_ts   (ts_val),
        .ld_tsen (cfg.tsen),
        .ld_pre  (cfg.pre),
        .busy    (ser_busy),
        .done    (ser_done),
        .done_ch (done_ch),
        .bclk    (trc_clk),
        .bdat    (trc_dat)
    );
endmodule

// File: rtl/trc_serializer_chk.sv
module trc_serializer_chk
    import trc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              trc_clk,
    input logic              trc_dat,
    input logic              ser_busy,
    input logic              arb_load,
    input logic [NCH-1:0]    arb_grant,
    input logic [NCH-1:0]    ch_en,
    input logic [TS_W-1:0]   ts_val
);
    // R4
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_busy |-> (!trc_clk && !trc_dat));

    // R6
    dat_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trc_dat) |-> !trc_clk);

    // R10
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_load |-> !ser_busy);

    // R10
    load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_load |=> ser_busy);

    // R10
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_grant));

    // R9
    grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_grant & ~ch_en) == '0);

    // R8
    ts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0 && reg_wdata[TSCLR_BIT]) |=> (ts_val == '0));
endmodule

bind trc_serializer trc_serializer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .trc_clk   (trc_clk),
    .trc_dat   (trc_dat),
    .ser_busy  (ser_busy),
    .arb_load  (arb_load),
    .arb_grant (arb_grant),
    .ch_en     (cfg.en),
    .ts_val    (ts_val)
);

// File: tb/trc_serializer_tb.sv
module trc_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trc_clk;
    logic        trc_dat;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    trc_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trc_clk   (trc_clk),
        .trc_dat   (trc_dat)
    );

    // receiver: capture data at each rising bit clock
    logic rx_bits [0:1023];
    int   rx_n = 0;
    logic prev_clk = 1'b0, prev_dat = 1'b0;
    int   hi_run = 0, lo_run = 0, hi_len = 0, lo_len = 0;
    logic [15:0] ts_m = '0, ts_prev_m = '0, start_ts = '0;
    logic        tsen_m = 1'b0;

    // timestamp model from R7/R8
    always @(posedge clk) begin
        ts_prev_m = ts_m;
        if (!rst_n) begin
            ts_m = '0;
            tsen_m = 1'b0;
        end else begin
            if (reg_wr && reg_addr == 6'h00 && reg_wdata[4]) ts_m = '0;
            else if (tsen_m) ts_m = ts_m + 16'd1;
            if (reg_wr && reg_addr == 6'h00) tsen_m = reg_wdata[3];
        end
    end

    always @(negedge clk) begin
        if (trc_clk && !prev_clk) begin
            if (rx_n < 1024) rx_bits[rx_n] = trc_dat;
            rx_n = rx_n + 1;
            lo_len = lo_run;
        end
        if (!trc_clk && prev_clk) hi_len = hi_run;
        if (trc_clk) begin hi_run = (prev_clk ? hi_run : 0) + 1; end
        else begin lo_run = (prev_clk ? 0 : lo_run) + 1; end
        if (trc_dat && !prev_dat && !prev_clk) start_ts = ts_prev_m;
        prev_clk = trc_clk;
        prev_dat = trc_dat;
    end

    function automatic logic [31:0] rxf(int pos, int w);
        logic [31:0] v = '0;
        for (int k = 0; k < w; k++) v = (v << 1) | 32'(rx_bits[pos + k]);
        return v;
    endfunction

    function automatic logic [31:0] cfgw(logic [2:0] en, logic tsen, logic clr, logic [1:0] pre);
        return {24'b0, pre, 1'b0, clr, tsen, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] a, b, c;
        for (int i = 0; i < 5000; i++) begin
            rd(6'h04, a); rd(6'h08, b); rd(6'h0C, c);
            if (a == 0 && b == 0 && c == 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic rx_clear();
        @(negedge clk);
        rx_n = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 trc_clk", 32'(trc_clk), 0);
        chk("R1 trc_dat", 32'(trc_dat), 0);
        rd(6'h00, v); chk("R1 cfg", v, 0);
        rd(6'h04, v); chk("R1 cmd1", v, 0);
        rd(6'h08, v); chk("R1 cmd2", v, 0);
        rd(6'h0C, v); chk("R1 cmd3", v, 0);
        rd(6'h18, v); chk("R1 par01 ch2", v, 0);
        rd(6'h2C, v); chk("R1 par23 ch3", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(6'h18, 32'hBEEF_1234);
        wr(6'h28, 32'hCAFE_5678);
        rd(6'h18, v); chk("R2 par01 ch2", v, 32'hBEEF_1234);
        rd(6'h28, v); chk("R2 par23 ch2", v, 32'hCAFE_5678);
        rd(6'h14, v); chk("R2 par01 ch1 untouched", v, 0);
        wr(6'h00, 32'h0000_01FF);
        rd(6'h00, v); chk("R2 R8 cfg readback", v, 32'h0000_00CF);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        wr(6'h00, cfgw(3'b111, 1'b0, 1'b0, 2'd0));
        rx_clear();
        wr(6'h08, 32'h0000_A502);
        rd(6'h08, v); chk("R3 cmd held", v, 32'h0000_A502);
        wait_idle();
        rd(6'h08, v); chk("R3 cmd cleared", v, 0);
        chk("R4 length", rx_n, 43);
        chk("R4 start", rxf(0, 1), 1);
        chk("R4 channel", rxf(1, 2), 2);
        chk("R4 header", rxf(3, 8), 32'hA5);
        chk("R4 param0", rxf(11, 16), 32'h1234);
        chk("R4 param1", rxf(27, 16), 32'hBEEF);
        chk("R4 idle", 32'({trc_clk, trc_dat}), 0);
    endtask

    task automatic t_count();
        rx_clear();
        wr(6'h04, 32'h0000_5A00);
        wait_idle();
        chk("R5 count0 length", rx_n, 11);
        chk("R5 count0 header", rxf(3, 8), 32'h5A);
        wr(6'h14, 32'h2222_1111);
        wr(6'h24, 32'h4444_3333);
        rx_clear();
        wr(6'h04, 32'h0000_9607);
        wait_idle();
        chk("R5 clamp length", rx_n, 75);
        chk("R5 clamp channel", rxf(1, 2), 1);
        chk("R5 p0", rxf(11, 16), 32'h1111);
        chk("R5 p1", rxf(27, 16), 32'h2222);
        chk("R5 p2", rxf(43, 16), 32'h3333);
        chk("R5 p3", rxf(59, 16), 32'h4444);
    endtask

    task automatic t_presc();
        for (int p = 0; p < 4; p++) begin
            wr(6'h00, cfgw(3'b111, 1'b0, 1'b0, 2'(p)));
            wr(6'h14, {16'h0, 16'h8001 ^ 16'(p)});
            rx_clear();
            wr(6'h04, 32'h0000_3C01);
            wait_idle();
            chk("R6 length", rx_n, 27);
            chk("R6 header", rxf(3, 8), 32'h3C);
            chk("R6 param", rxf(11, 16), 32'(16'h8001 ^ 16'(p)));
            chk("R6 high time", hi_len, p + 1);
            chk("R6 low time", lo_len, p + 1);
        end
    endtask

    task automatic t_tstamp();
        logic [31:0] v;
        wr(6'h00, cfgw(3'b001, 1'b1, 1'b1, 2'd0));
        repeat (37) @(negedge clk);
        rx_clear();
        wr(6'h04, 32'h0000_7700);
        wait_idle();
        chk("R7 ts length", rx_n, 27);
        chk("R7 ts value", rxf(11, 16), 32'(start_ts));
        chk("R7 ts nonzero", 32'(start_ts > 16'd30), 1);
        rd(6'h00, v); chk("R8 clear reads 0", v, 32'h0000_0009);
        wr(6'h00, cfgw(3'b001, 1'b0, 1'b0, 2'd0));
        rx_clear();
        wr(6'h04, 32'h0000_7800);
        wait_idle();
        chk("R7 no ts length", rx_n, 11);
        wr(6'h00, cfgw(3'b001, 1'b0, 1'b1, 2'd0));
        repeat (20) @(negedge clk);
        wr(6'h00, cfgw(3'b001, 1'b1, 1'b0, 2'd0));
        repeat (5) @(negedge clk);
        rx_clear();
        wr(6'h04, 32'h0000_7900);
        wait_idle();
        chk("R8 ts after clear", rxf(11, 16), 32'(start_ts));
        chk("R8 ts small", 32'(start_ts < 16'd20), 1);
        wr(6'h00, cfgw(3'b111, 1'b0, 1'b0, 2'd0));
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr(6'h00, cfgw(3'b001, 1'b0, 1'b0, 2'd0));
        rx_clear();
        wr(6'h0C, 32'h0000_AB02);
        rd(6'h0C, v); chk("R9 disabled cmd reads 0", v, 0);
        repeat (60) @(negedge clk);
        chk("R9 no frame", rx_n, 0);
        chk("R9 line idle", 32'({trc_clk, trc_dat}), 0);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(6'h00, cfgw(3'b111, 1'b0, 1'b0, 2'd0));
        rx_clear();
        wr(6'h0C, 32'h0000_3300);
        wr(6'h08, 32'h0000_2200);
        wr(6'h04, 32'h0000_1100);
        wr(6'h08, 32'h0000_5503);
        rd(6'h08, v); chk("R11 cmd2 kept", v, 32'h0000_2200);
        rd(6'h04, v); chk("R10 cmd1 queued", v, 32'h0000_1100);
        wait_idle();
        chk("R10 total length", rx_n, 33);
        chk("R10 first channel", rxf(1, 2), 3);
        chk("R10 first header", rxf(3, 8), 32'h33);
        chk("R10 second channel", rxf(12, 2), 1);
        chk("R10 second header", rxf(14, 8), 32'h11);
        chk("R10 third channel", rxf(23, 2), 2);
        chk("R11 third header", rxf(25, 8), 32'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic();
        t_count();
        t_presc();
        t_tstamp();
        t_disabled();
        t_prio();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule